// File: doc/BRIEF.md
# Palette Lookup Table Write Port

This block holds a 256-entry table of 24-bit colours and loads it through a narrow register interface driven by 32-bit bus writes. Every register carries its byte in the top 8 bits of the bus word; bits 23:0 are ignored. Software first writes an entry number to the index register. It then writes the colour register three times: red, then green, then blue. The third write stores the whole 24-bit entry in one cycle and moves the pointer to the next entry. A further colour triple therefore fills consecutive entries with no new index write.

The same pointer also selects a small bank of four control bytes. These sit at pointer values 4 to 7 and are written through a separate control register. A typical start-up sequence loads 0xFF, 0x00, 0x73 and 0x00 into them. A separate lookup port turns an 8-bit pixel index into its stored RGB value one clock later.

The component order is held by a state machine with three states:
- `PH_RED` waits for the red byte. A colour write moves it to `PH_GREEN`.
- `PH_GREEN` waits for the green byte. A colour write moves it to `PH_BLUE`.
- `PH_BLUE` waits for the blue byte. A colour write commits the entry, increments the pointer and returns to `PH_RED`.
- An index write sends any state back to `PH_RED`.

Top module: `pal_wr_port`

## Requirements
- R1: After reset, every table entry reads as 0, all four control bytes are 0, and the lookup output is 0.
- R2: A write with `wr_sel`=2'b00 (index register) loads the pointer from `wr_data[31:24]`. The next three writes with `wr_sel`=2'b01 (colour register) supply red, green and blue. The entry is stored as {red,green,blue}, with red in bits 23:16 of the lookup output.
- R3: An entry does not change until the blue byte of its triple is written. The red or green write alone leaves the table unchanged.
- R4: The blue write increments the pointer by one, wrapping from 255 to 0. A following triple fills the next entry.
- R5: An index write in the middle of a triple discards the components already given and restarts at red.
- R6: A write with `wr_sel`=2'b10 (control register) stores `wr_data[31:24]` into control byte k when the pointer equals 4+k (k=0..3). Byte k appears at `ctrl_q[8k+7:8k]`. With any other pointer value, the control write has no effect.
- R7: `pix_rgb` shows the entry addressed by `pix_idx` one clock after the index is presented. If the index is written in that same clock edge, the lookup returns the value the entry held before that write.
- R8: Bits 23:0 of every bus write are ignored.
- R9: Control writes and writes with `wr_sel`=2'b11 leave the pointer and the component state unchanged. This holds even in the middle of a triple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_sel | input | 2 | Register select: 00 index, 01 colour, 10 control, 11 unused |
| wr_data | input | 32 | Write data; the payload byte is in bits 31:24 |
| pix_idx | input | 8 | Pixel index for the lookup port |
| pix_rgb | output | 24 | Looked-up colour {R,G,B}, registered |
| ctrl_q | output | 32 | Four control bytes, byte k in bits 8k+7:8k |

## Verification
The bench targets five corner cases:
- A partial triple. A design that commits early would expose a half-written entry.
- An index write mid-triple. A design that keeps the old phase would shift the colours by one component.
- The pointer wrap from 255 to 0. A design that saturates or drops the carry would overwrite the wrong entry.
- Control writes with the pointer outside 4 to 7, and control writes in the middle of a triple. A design that decodes loosely or resets the phase would corrupt either the control bank or the entry.
- A lookup of an entry in the cycle it is written. A design with write-through or a missing output register would show the new value too early, or one clock off.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        SEL_INDEX  = 2'b00,
        SEL_COLOUR = 2'b01,
        SEL_CTRL   = 2'b10,
        SEL_NONE   = 2'b11
    } bus_sel_e;

    typedef enum logic [1:0] {
        PH_RED   = 2'b00,
        PH_GREEN = 2'b01,
        PH_BLUE  = 2'b10
    } phase_e;

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_load,
    input  logic [IDX_W-1:0]  idx_val,
    input  logic              comp_wr,
    input  logic [COMP_W-1:0] comp_val,
    output logic [IDX_W-1:0]  ptr_q,
    output phase_e            phase_q,
    output logic              commit,
    output logic [RGB_W-1:0]  commit_rgb
);

    phase_e            phase_d;
    logic [COMP_W-1:0] red_q, green_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_RED;
        else        phase_q <= phase_d;
    end

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        if (idx_load) begin
            phase_d = PH_RED;
        end else if (comp_wr) begin
            unique case (phase_q)
                PH_RED:   phase_d = PH_GREEN;
                PH_GREEN: phase_d = PH_BLUE;
                PH_BLUE:  phase_d = PH_RED;
                default:  phase_d = PH_RED;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        commit     = comp_wr && !idx_load && (phase_q == PH_BLUE);
        commit_rgb = {red_q, green_q, comp_val};
    end

    // Component staging and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            red_q   <= '0;
            green_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (comp_wr && phase_q == PH_RED)   red_q   <= comp_val;
            if (comp_wr && phase_q == PH_GREEN) green_q <= comp_val;
            if (idx_load)    ptr_q <= idx_val;
            else if (commit) ptr_q <= ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 24,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
            if (we) mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl #(
    parameter int IDX_W     = 8,
    parameter int COMP_W    = 8,
    parameter int CTRL_N    = 4,
    parameter int CTRL_BASE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_wr,
    input  logic [IDX_W-1:0]         ptr,
    input  logic [COMP_W-1:0]        wval,
    output logic [CTRL_N*COMP_W-1:0] ctrl_q
);

    for (genvar k = 0; k < CTRL_N; k++) begin : g_reg
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(CTRL_BASE + k);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q[k*COMP_W +: COMP_W] <= '0;
            else if (ctrl_wr && ptr == SLOT)
                ctrl_q[k*COMP_W +: COMP_W] <= wval;
        end
    end

endmodule

// File: rtl/pal_wr_port.sv
module pal_wr_port
    import pal_pkg::*;
#(
    parameter int BUS_W     = 32,
    parameter int IDX_W     = 8,
    parameter int COMP_W    = 8,
    parameter int CTRL_N    = 4,
    parameter int CTRL_BASE = 4,
    localparam int RGB_W    = 3 * COMP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [BUS_W-1:0]         wr_data,
    input  logic [IDX_W-1:0]         pix_idx,
    output logic [RGB_W-1:0]         pix_rgb,
    output logic [CTRL_N*COMP_W-1:0] ctrl_q
);

    logic [COMP_W-1:0] wr_byte;
    logic [IDX_W-1:0]  wr_index;
    logic              idx_load, comp_wr, ctrl_wr, commit;
    logic [IDX_W-1:0]  ptr_q;
    phase_e            phase_q;
    logic [RGB_W-1:0]  commit_rgb;

    always_comb begin
        wr_byte  = wr_data[BUS_W-1 -: COMP_W];
        wr_index = wr_data[BUS_W-1 -: IDX_W];
        idx_load = wr_en && (wr_sel == SEL_INDEX);
        comp_wr  = wr_en && (wr_sel == SEL_COLOUR);
        ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
    end

    pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .idx_load(idx_load), .idx_val(wr_index),
        .comp_wr(comp_wr), .comp_val(wr_byte),
        .ptr_q(ptr_q), .phase_q(phase_q),
        .commit(commit), .commit_rgb(commit_rgb)
    );

    pal_ram #(.IDX_W(IDX_W), .DATA_W(RGB_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(commit), .waddr(ptr_q), .wdata(commit_rgb),
        .raddr(pix_idx), .rdata(pix_rgb)
    );

    pal_ctrl #(.IDX_W(IDX_W), .COMP_W(COMP_W), .CTRL_N(CTRL_N),
               .CTRL_BASE(CTRL_BASE)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ptr(ptr_q), .wval(wr_byte),
        .ctrl_q(ctrl_q)
    );

endmodule

// File: rtl/pal_wr_port_chk.sv
module pal_wr_port_chk
    import pal_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int IDX_W  = 8,
    parameter int CTRL_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [BUS_W-1:0]  wr_data,
    input logic [IDX_W-1:0]  ptr,
    input phase_e            phase,
    input logic              commit,
    input logic [CTRL_W-1:0] ctrl_q
);

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_INDEX) |=>
            (ptr == $past(wr_data[BUS_W-1 -: IDX_W]) && phase == PH_RED));

    // R4
    auto_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (ptr == IDX_W'($past(ptr) + 1)));

    // R3
    commit_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (phase == PH_BLUE && wr_en && wr_sel == SEL_COLOUR));

    // R6
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_CTRL) |=> $stable(ctrl_q));

    // R9
    side_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_CTRL || wr_sel == SEL_NONE)) |=>
            ($stable(ptr) && $stable(phase)));

endmodule

bind pal_wr_port pal_wr_port_chk #(
    .BUS_W(BUS_W), .IDX_W(IDX_W), .CTRL_W(CTRL_N*COMP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ptr(ptr_q), .phase(phase_q),
    .commit(commit), .ctrl_q(ctrl_q)
);

// File: tb/pal_wr_port_tb.sv
module pal_wr_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b11;
    logic [31:0] wr_data = '0;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic [31:0] ctrl_q;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    pal_wr_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
        .ctrl_q(ctrl_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [23:0] ref_mem [256];
    int          ref_ptr, ref_ph;
    logic [7:0]  ref_r, ref_g, b;
    logic [31:0] exp_ctrl;
    logic [23:0] exp_pix;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ref_mem[i]) ref_mem[i] = '0;
            ref_ptr = 0; ref_ph = 0; exp_ctrl = '0; exp_pix = '0;
            ref_r = '0; ref_g = '0;
        end else begin
            exp_pix = ref_mem[pix_idx];
            if (wr_en) begin
                b = wr_data[31:24];
                case (wr_sel)
                    2'b00: begin ref_ptr = int'(b); ref_ph = 0; end
                    2'b01: begin
                        if (ref_ph == 0)      begin ref_r = b; ref_ph = 1; end
                        else if (ref_ph == 1) begin ref_g = b; ref_ph = 2; end
                        else begin
                            ref_mem[ref_ptr] = {ref_r, ref_g, b};
                            ref_ptr = (ref_ptr + 1) % 256;
                            ref_ph = 0;
                        end
                    end
                    2'b10: if (ref_ptr >= 4 && ref_ptr <= 7)
                               exp_ctrl[(ref_ptr-4)*8 +: 8] = b;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({8'h0, pix_rgb}, {8'h0, exp_pix}, "R7 per-cycle lookup");
            check(ctrl_q, exp_ctrl, "R6 per-cycle control bank");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] v, input logic [23:0] junk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = {v, junk};
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11; wr_data = '0;
    endtask

    task automatic triple(input logic [7:0] r, input logic [7:0] g, input logic [7:0] bl);
        bus_wr(2'b01, r, 24'hA5A5A5);
        bus_wr(2'b01, g, 24'h5A5A5A);
        bus_wr(2'b01, bl, 24'hFFFFFF);
    endtask

    task automatic peek(input logic [7:0] idx, input logic [23:0] exp, input string tag);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        check({8'h0, pix_rgb}, {8'h0, exp}, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({8'h0, pix_rgb}, 32'h0, "R1 reset lookup");
        check(ctrl_q, 32'h0, "R1 reset control bank");
        peek(8'h80, 24'h0, "R1 reset entry");

        // Start-up control sequence
        bus_wr(2'b00, 8'h04, 24'h0); bus_wr(2'b10, 8'hFF, 24'h123456);
        bus_wr(2'b00, 8'h05, 24'h0); bus_wr(2'b10, 8'h00, 24'hFFFFFF);
        bus_wr(2'b00, 8'h06, 24'h0); bus_wr(2'b10, 8'h73, 24'h0);
        bus_wr(2'b00, 8'h07, 24'h0); bus_wr(2'b10, 8'h00, 24'h0);
        @(negedge clk);
        check(ctrl_q, 32'h0073_00FF, "R6 control init sequence");
        bus_wr(2'b00, 8'h09, 24'h0); bus_wr(2'b10, 8'hEE, 24'h0);
        @(negedge clk);
        check(ctrl_q, 32'h0073_00FF, "R6 control write outside slots ignored");

        // Basic triple with noisy low bits
        bus_wr(2'b00, 8'h10, 24'hABCDEF);
        triple(8'h11, 8'h22, 8'h33);
        peek(8'h10, 24'h112233, "R2 R8 triple stored");

        // Partial triple then restart
        bus_wr(2'b00, 8'h20, 24'h0);
        bus_wr(2'b01, 8'hAA, 24'h0);
        bus_wr(2'b01, 8'hBB, 24'h0);
        peek(8'h20, 24'h0, "R3 partial triple not stored");
        bus_wr(2'b00, 8'h20, 24'h0);
        triple(8'h01, 8'h02, 8'h03);
        peek(8'h20, 24'h010203, "R5 index write restarts at red");

        // Auto-increment
        triple(8'h04, 8'h05, 8'h06);
        peek(8'h21, 24'h040506, "R4 auto-increment");

        // Wrap 255 -> 0
        bus_wr(2'b00, 8'hFF, 24'h0);
        triple(8'h07, 8'h08, 8'h09);
        triple(8'h0A, 8'h0B, 8'h0C);
        peek(8'hFF, 24'h070809, "R4 last entry");
        peek(8'h00, 24'h0A0B0C, "R4 wrap to entry 0");

        // Side writes in the middle of a triple
        bus_wr(2'b00, 8'h30, 24'h0);
        bus_wr(2'b01, 8'hC1, 24'h0);
        bus_wr(2'b10, 8'h99, 24'h0);
        bus_wr(2'b11, 8'h77, 24'h0);
        bus_wr(2'b01, 8'hC2, 24'h0);
        bus_wr(2'b01, 8'hC3, 24'h0);
        peek(8'h30, 24'hC1C2C3, "R9 side writes keep sequence");
        check(ctrl_q, 32'h0073_00FF, "R9 control write at pointer 0x30 ignored");

        // Lookup of an entry in the cycle it is written
        bus_wr(2'b00, 8'h40, 24'h0);
        bus_wr(2'b01, 8'hD1, 24'h0);
        bus_wr(2'b01, 8'hD2, 24'h0);
        @(negedge clk);
        pix_idx = 8'h40; wr_en = 1'b1; wr_sel = 2'b01; wr_data = {8'hD3, 24'h0};
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11;
        check({8'h0, pix_rgb}, 32'h0, "R7 same-cycle write returns old value");
        @(negedge clk);
        check({8'h0, pix_rgb}, 32'h00D1D2D3, "R7 new value one clock later");

        // Random traffic checked by the per-cycle model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            pix_idx = 8'($urandom);
            wr_en   = 1'($urandom);
            wr_sel  = 2'($urandom);
            wr_data = $urandom;
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule